// File: doc/BRIEF.md
# SAR Conversion Sequencer Accelerator

This block helps firmware run a successive-approximation conversion. The conversion uses a 6-bit DAC code register and a set of column comparators. Firmware first writes a control register with a step count, a comparator-sense flag and a column selector. It then loads the DAC register with the top bit set as the first trial. After that it performs one read-modify-write of the DAC register per code bit.

While the step count is nonzero, each read of the DAC register is intercepted. The block samples the selected comparator and decides whether the bit under trial stays or is cleared. It also sets the next lower bit as the following trial. It returns that corrected byte to the CPU and decrements the count. The CPU writes the corrected value back unchanged, and that write is what stores it. After six steps from a count of 6, the code tracks the input to within one LSB. When the count is zero, the DAC register reads back plainly.

Top module: `sar_seq_accel`

## Requirements
- R1: After reset, the control register reads 00h, the DAC register and `dac_code` are 0, `rd_data` is 0 and `sync_en_o` is 0.
- R2: The control register, at address CTRL_ADDR, has this layout: bits 6:4 are the step count, bit 3 is the sense flag, bits 2:1 select the column, and bit 0 is a pass-through enable driven on `sync_en_o`. Bit 7 always reads 0.
- R3: A DAC-register read with count n != 0 resolves bit n-1. The bit is kept if the effective comparator value is 1 and cleared if it is 0. Bits above n-1 and bits 7:6 return unchanged.
- R4: On such a read, bit n-2 is returned set when n > 1. When n = 1, no other bit is set. Bits below n-2 return unchanged.
- R5: Each intercepted read lowers the count by one, and a control read shows the new count.
- R6: With count 0, a DAC-register read returns the stored byte unmodified, and the count stays 0.
- R7: The effective comparator value is the raw comparator value XOR the sense flag. Sense 1 inverts the keep decision.
- R8: The comparator sampled is `cmp_col[col]`, where col is control bits 2:1. Other columns have no effect.
- R9: Only a bus write changes the DAC register. `dac_code` is its bits 5:0. An intercepted read alone leaves `dac_code` unchanged.
- R10: Six read/write-back steps from count 6 and trial 20h leave `dac_code` equal to the input level when the comparator is 1 for input >= trial.
- R11: Read data is registered and appears on the cycle after `rd_en`. Reads of any other address return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Register address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| cmp_col | input | NCOL | Comparator output per column |
| dac_code | output | CODE_W | Current DAC code |
| sync_en_o | output | 1 | Control bit 0 pass-through |

## Verification
The assertions assume that read and write strobes are never active in the same cycle. They also assume that the comparator inputs are steady during the cycle in which a read strobe is sampled. The bench drives each access as a single strobe of one cycle, launched on the falling edge. It sets the comparator lines before it raises the read strobe. It drives each unselected column to the opposite of the selected one, so that a wrong column choice shows up as a wrong resolved bit.

// File: rtl/sar_pkg.sv
// Shared field layout and types for the SAR sequencer.
// Assumes an 8-bit register bus.
package sar_pkg;
    localparam int DATA_W  = 8;
    localparam int CNT_W   = 3;
    localparam int COL_W   = 2;
    localparam int CNT_LSB = 4;
    localparam int SNS_BIT = 3;
    localparam int COL_LSB = 1;
    localparam int EN_BIT  = 0;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sense;
        logic [COL_W-1:0] col;
        logic             en;
    } ctrl_t;

    // Unpack a bus byte into the control fields (bit 7 dropped).
    function automatic ctrl_t unpack_ctrl(input logic [DATA_W-1:0] b);
        ctrl_t c;
        c.cnt   = b[CNT_LSB +: CNT_W];
        c.sense = b[SNS_BIT];
        c.col   = b[COL_LSB +: COL_W];
        c.en    = b[EN_BIT];
        return c;
    endfunction

    // Pack the control fields back into a bus byte, bit 7 zero.
    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c);
        logic [DATA_W-1:0] b;
        b = '0;
        b[CNT_LSB +: CNT_W] = c.cnt;
        b[SNS_BIT]          = c.sense;
        b[COL_LSB +: COL_W] = c.col;
        b[EN_BIT]           = c.en;
        return b;
    endfunction
endpackage

// File: rtl/sar_ctrl_reg.sv
// Control register with step down-counter.
// Assumes wr_en and step are not active together in normal use; a write wins.
module sar_ctrl_reg
    import sar_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              step,
    output ctrl_t             ctrl_q
);
    // Load on write, count down on each intercepted read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= unpack_ctrl(wr_data);
        end else if (step && (ctrl_q.cnt != '0)) begin
            ctrl_q.cnt <= ctrl_q.cnt - 1'b1;
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr_en && ctrl_q.cnt != '0) |=> ctrl_q.cnt == $past(ctrl_q.cnt) - 1'b1); // R5
    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.cnt == '0 && !wr_en) |=> ctrl_q.cnt == '0); // R6
endmodule

// File: rtl/sar_col_pick.sv
// Selects one comparator column and applies the sense flag.
// Assumes NCOL <= 2**COL_W; a column index outside the range reads as 0.
module sar_col_pick
    import sar_pkg::*;
#(
    parameter int NCOL = 4
) (
    input  logic [NCOL-1:0]  cmp_col,
    input  logic [COL_W-1:0] col,
    input  logic             sense,
    output logic             keep
);
    logic [NCOL-1:0] hit;

    // One-hot decode of the column index, masked by the comparator lines.
    for (genvar i = 0; i < NCOL; i++) begin : g_col
        assign hit[i] = (col == COL_W'(i)) & cmp_col[i];
    end

    // Effective comparator: the selected line XOR the sense flag.
    always_comb begin
        keep = (|hit) ^ sense;
    end
endmodule

// File: rtl/sar_step_logic.sv
// Computes the corrected DAC code for one SAR step.
// With count n it resolves bit n-1 and sets bit n-2 when n > 1.
// Assumes CODE_W < 2**CNT_W.
module sar_step_logic
    import sar_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic [CODE_W-1:0] code_in,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              keep,
    output logic [CODE_W-1:0] code_out
);
    // Per-bit rule: resolve, set the next trial, or pass through.
    for (genvar i = 0; i < CODE_W; i++) begin : g_bit
        always_comb begin
            if (cnt == CNT_W'(i + 1)) begin
                code_out[i] = code_in[i] & keep;
            end else if (cnt == CNT_W'(i + 2)) begin
                code_out[i] = 1'b1;
            end else begin
                code_out[i] = code_in[i];
            end
        end
    end
endmodule

// File: rtl/sar_dac_reg.sv
// DAC code register; only a bus write changes it.
module sar_dac_reg
    import sar_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] dac_q
);
    // Store the written byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_q <= '0;
        end else if (wr_en) begin
            dac_q <= wr_data;
        end
    end

    AST_DAC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(dac_q)); // R9
endmodule

// File: rtl/sar_seq_accel.sv
// SAR conversion sequencer top level.
// Intercepts reads of the DAC register while the step count is nonzero.
// Assumes rd_en and wr_en are never asserted in the same cycle.
module sar_seq_accel
    import sar_pkg::*;
#(
    parameter int                CODE_W    = 6,
    parameter int                NCOL      = 4,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h30,
    parameter logic [ADDR_W-1:0] DAC_ADDR  = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    input  logic [NCOL-1:0]   cmp_col,
    output logic [CODE_W-1:0] dac_code,
    output logic              sync_en_o
);
    localparam int UPPER_W = DATA_W - CODE_W;

    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] dac_q;
    logic [CODE_W-1:0] fixed_code;
    logic              keep;
    logic              hit_ctrl;
    logic              hit_dac;
    logic              step;
    logic [DATA_W-1:0] rd_next;

    // Address decode and step qualification.
    always_comb begin
        hit_ctrl = (addr == CTRL_ADDR);
        hit_dac  = (addr == DAC_ADDR);
        step     = rd_en && hit_dac && (ctrl_q.cnt != '0);
    end

    sar_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en && hit_ctrl),
        .wr_data (wr_data),
        .step    (step),
        .ctrl_q  (ctrl_q)
    );

    sar_dac_reg u_dac (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en && hit_dac),
        .wr_data (wr_data),
        .dac_q   (dac_q)
    );

    sar_col_pick #(.NCOL(NCOL)) u_pick (
        .cmp_col (cmp_col),
        .col     (ctrl_q.col),
        .sense   (ctrl_q.sense),
        .keep    (keep)
    );

    sar_step_logic #(.CODE_W(CODE_W)) u_step (
        .code_in  (dac_q[CODE_W-1:0]),
        .cnt      (ctrl_q.cnt),
        .keep     (keep),
        .code_out (fixed_code)
    );

    // Read-data source: control, corrected or plain DAC, else zero.
    always_comb begin
        if (hit_ctrl) begin
            rd_next = pack_ctrl(ctrl_q);
        end else if (step) begin
            rd_next = {dac_q[DATA_W-1 -: UPPER_W], fixed_code};
        end else if (hit_dac) begin
            rd_next = dac_q;
        end else begin
            rd_next = '0;
        end
    end

    // Register read data on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_next;
        end
    end

    // Drive the DAC code and enable outputs.
    always_comb begin
        dac_code  = dac_q[CODE_W-1:0];
        sync_en_o = ctrl_q.en;
    end

    AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hit_dac && ctrl_q.cnt == '0) |=> rd_data == $past(dac_q)); // R6
    AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (rd_data >> $past(ctrl_q.cnt)) == ($past(dac_q) >> $past(ctrl_q.cnt))); // R3
    AST_DROP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !keep) |=> ((rd_data >> ($past(ctrl_q.cnt) - 3'd1)) & 8'd1) == 8'd0); // R3
    AST_NEXT_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
        (step && ctrl_q.cnt > 3'd1) |=> ((rd_data >> ($past(ctrl_q.cnt) - 3'd2)) & 8'd1) == 8'd1); // R4
    AST_OTHER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !hit_ctrl && !hit_dac) |=> rd_data == 8'd0); // R11
    AST_CTRL_B7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hit_ctrl) |=> rd_data[7] == 1'b0); // R2
endmodule

// File: tb/sar_seq_accel_tb.sv
// Scoreboard bench: the driver pushes expected read data, the monitor compares.
module sar_seq_accel_tb_top;
    localparam logic [7:0] CA = 8'h30;
    localparam logic [7:0] DA = 8'h40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = '0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [3:0] cmp_col = '0;
    logic [5:0] dac_code;
    logic       sync_en_o;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_d = 1'b0;

    logic [7:0] m_ctrl = '0;
    logic [7:0] m_dac = '0;
    logic [7:0] last_exp;

    always #5 clk = ~clk;

    sar_seq_accel dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .cmp_col(cmp_col),
        .dac_code(dac_code), .sync_en_o(sync_en_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    always @(posedge clk) rd_d <= rd_en;

    // Monitor: compare registered read data against the scoreboard.
    always @(negedge clk) begin
        if (rd_d && exp_q.size() > 0) begin
            chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
        end
    end

    function automatic logic [7:0] corrected(input logic [7:0] d, input int n, input logic k);
        logic [7:0] r;
        r = d;
        if (!k) r[n-1] = 1'b0;
        if (n > 1) r[n-2] = 1'b1;
        return r;
    endfunction

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        if (a == CA) m_ctrl = d & 8'h7F;
        if (a == DA) m_dac = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input string tag);
        logic [7:0] e;
        int n;
        logic k;
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        n = int'(m_ctrl[6:4]);
        k = cmp_col[m_ctrl[2:1]] ^ m_ctrl[3];
        if (a == CA) e = m_ctrl;
        else if (a == DA && n != 0) begin
            e = corrected(m_dac, n, k);
            m_ctrl[6:4] = m_ctrl[6:4] - 3'd1;
        end else if (a == DA) e = m_dac;
        else e = 8'h00;
        last_exp = e;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Drive comparators: selected column reflects vin >= trial, others opposite.
    task automatic set_cmp(input int vin);
        logic v;
        v = (vin >= int'(m_dac[5:0])) ^ m_ctrl[3];
        for (int i = 0; i < 4; i++) cmp_col[i] = (i == int'(m_ctrl[2:1])) ? v : ~v;
    endtask

    task automatic convert(input int vin, input logic sns, input logic [1:0] col);
        bus_write(CA, {1'b0, 3'd6, sns, col, 1'b1});
        bus_write(DA, 8'h60);
        for (int s = 0; s < 6; s++) begin
            set_cmp(vin);
            bus_read(DA, "R3/R4/R7/R8 step");
            bus_write(DA, last_exp);
        end
        @(negedge clk);
        chk("R10 final code", {2'b00, dac_code}, 8'(vin));
        bus_read(CA, "R5 count done");
        bus_read(DA, "R6 plain read");
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 dac_code", {2'b00, dac_code}, 8'h00);
        chk("R1 rd_data", rd_data, 8'h00);
        chk("R1 sync_en", {7'd0, sync_en_o}, 8'h00);
        bus_read(CA, "R1 ctrl reset");
        bus_read(DA, "R1 dac reset");

        bus_write(CA, 8'hFF);
        bus_read(CA, "R2 ctrl bit7 zero");
        chk("R2 sync_en", {7'd0, sync_en_o}, 8'h01);
        bus_write(CA, 8'h0A);
        bus_read(CA, "R2 ctrl layout");
        chk("R2 sync_en off", {7'd0, sync_en_o}, 8'h00);
        bus_read(8'h55, "R11 other addr");

        convert(37, 1'b0, 2'd0);
        convert(0, 1'b0, 2'd3);
        convert(63, 1'b1, 2'd1);
        convert(22, 1'b1, 2'd2);
        convert(32, 1'b0, 2'd1);

        // Partial sequence: count 3, trial bit 2, drop it.
        bus_write(CA, {1'b0, 3'd3, 1'b0, 2'd2, 1'b0});
        bus_write(DA, 8'h84);
        cmp_col = 4'b1011;
        bus_read(DA, "R3 drop bit2 R4 set bit1");
        @(negedge clk);
        chk("R9 no store on read", {2'b00, dac_code}, 8'h04);
        bus_write(DA, last_exp);
        bus_read(CA, "R5 count 2");
        cmp_col = 4'b0100;
        bus_read(DA, "R4 keep bit1 set bit0");
        bus_write(DA, last_exp);
        cmp_col = 4'b0000;
        bus_read(DA, "R4 n=1 no new trial");
        bus_write(DA, last_exp);
        bus_read(DA, "R6 count zero");
        bus_read(CA, "R6 count stays 0");

        // Sense flag inverts: raw 1 with sense 1 clears.
        bus_write(CA, {1'b0, 3'd1, 1'b1, 2'd0, 1'b0});
        bus_write(DA, 8'h01);
        cmp_col = 4'b0001;
        bus_read(DA, "R7 sense inverts");

        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule